// File: doc/BRIEF.md
# NAND Flash Host Front-End

This block connects a register-mapped processor bus to an 8-bit NAND flash device. Software places command bytes, address bytes and data bytes into a shared four-entry write buffer through three separate register offsets. A strobe engine drains the buffer one entry at a time. It raises the command-latch or address-latch line to match the entry's tag, drives the byte onto the flash data pins and pulses write-enable low for a programmable number of clocks.

A read is a two-step exchange. Software writes any value to a read-request register, and that request is queued behind any pending writes. The engine then pulses read-enable low and captures the flash byte into a read-data register. It also sets a read-ready event, which software acknowledges by writing a one to that event bit. The device's ready/busy line is synchronized, reported as a status bit and converted into an event on its rising edge. An interrupt line is raised when any event is set whose bit is enabled in the mask register.

Top module: `nfc_host_frontend`

## Requirements
- R1: The control register at offset 0x0 holds 10 bits: [3:0] write-strobe delay, [7:4] read-strobe delay, [8] data-width select and [9] page-size select. It reads back as written. Bits 8 and 9 have no effect on strobe timing.
- R2: Bytes written to offset 0x4 (command), 0x5 (address) and 0x6 (data) reach the flash in write order. A command byte goes out with the command-latch line high, an address byte with the address-latch line high, and a data byte with both latch lines low. The two latch lines are never high together, and the data-output enable is high only while write-enable is low.
- R3: The write buffer holds 4 entries. A write to offsets 0x4 to 0x7 while the buffer is full is dropped and sets event bit 1.
- R4: A write-enable low pulse lasts write-delay+1 clocks and a read-enable low pulse lasts read-delay+1 clocks. There is at least one high clock between strobes, and write-enable and read-enable are never low together.
- R5: A write of any value to offset 0x7 queues a read. The byte on the flash data input in the last low clock of read-enable appears at offset 0x8. Event bit 3 sets in the same cycle that read-enable rises.
- R6: The status register at offset 0x1 reports: bit 0 = ready line after two-flop synchronization, bit 1 = buffer full, bit 4 = buffer empty with no strobe active. Bits 2 and 3 read 0.
- R7: The event register at offset 0x2 works as follows. Bit 0 sets on a rising edge of the synchronized ready line. Bit 2 sets when the buffer leaves the full state. Bit 4 reads 0. Writing 1 to a bit clears it, and writing 0x1F clears all of them. A set in the same cycle as a clear wins.
- R8: The mask register is at offset 0x3. The interrupt output is high exactly when some event bit and its mask bit are both 1.
- R9: After reset: both strobes are high, both latch lines are low, events, mask and control are 0, the read-data register is 0, and status reads 0x11 while the ready line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Register write strobe, one per clock |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Read data for the offset on bus_addr (combinational) |
| irq | output | 1 | Masked event interrupt |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write enable, active low |
| nf_re_n | output | 1 | Read enable, active low |
| nf_dq_out | output | 8 | Data driven toward the flash |
| nf_dq_oe | output | 1 | Output enable for nf_dq_out |
| nf_dq_in | input | 8 | Data from the flash |
| nf_rb | input | 1 | Flash ready (high) / busy (low) |

## Verification
The assertions check several properties on every clock: the latch lines are never high together, the two strobes never overlap, the data-output enable stays inside write-enable, the buffer occupancy stays in bounds, a write into a full buffer raises the overflow event, and a rising read-enable coincides with read-ready. The following are shown only by the bench's scenarios, in which a behavioural model compares pins, events and every register readback on each clock: pulse widths, the order and tags of bytes at the flash, which burst byte is dropped, the captured read byte, and the ready-line edge event.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
    localparam int BYTE_W     = 8;
    localparam int DLY_W      = 4;
    localparam int CTRL_W     = 10;
    localparam int NUM_EV     = 5;
    localparam int REG_ADDR_W = 4;

    // event bit positions
    localparam int EV_RDY_RISE = 0;
    localparam int EV_OVF      = 1;
    localparam int EV_LEAVE_FULL = 2;
    localparam int EV_RD_READY = 3;

    // register offsets
    localparam logic [REG_ADDR_W-1:0] OFF_CTRL  = 4'h0;
    localparam logic [REG_ADDR_W-1:0] OFF_STAT  = 4'h1;
    localparam logic [REG_ADDR_W-1:0] OFF_EVT   = 4'h2;
    localparam logic [REG_ADDR_W-1:0] OFF_MASK  = 4'h3;
    localparam logic [REG_ADDR_W-1:0] OFF_CMD   = 4'h4;
    localparam logic [REG_ADDR_W-1:0] OFF_ADDR  = 4'h5;
    localparam logic [REG_ADDR_W-1:0] OFF_DATA  = 4'h6;
    localparam logic [REG_ADDR_W-1:0] OFF_RDREQ = 4'h7;
    localparam logic [REG_ADDR_W-1:0] OFF_RDATA = 4'h8;

    typedef enum logic [1:0] {
        TAG_CMD  = 2'd0,
        TAG_ADDR = 2'd1,
        TAG_DATA = 2'd2,
        TAG_READ = 2'd3
    } wb_tag_e;

    typedef struct packed {
        wb_tag_e             tag;
        logic [BYTE_W-1:0]   val;
    } wb_entry_t;
endpackage

// File: rtl/nfc_wbuf.sv
module nfc_wbuf
    import nfc_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  wb_entry_t        push_entry,
    input  logic             pop,
    output wb_entry_t        head,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        wb_entry_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]      wp;
        logic [PTR_W-1:0]      rp;
        logic [CNT_W-1:0]      cnt;
    } wbuf_t;

    wbuf_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (push) begin
            s_d.mem[s_q.wp] = push_entry;
            s_d.wp = (s_q.wp == PTR_W'(DEPTH - 1)) ? '0 : s_q.wp + PTR_W'(1);
        end
        if (pop) begin
            s_d.rp = (s_q.rp == PTR_W'(DEPTH - 1)) ? '0 : s_q.rp + PTR_W'(1);
        end
        case ({push, pop})
            2'b10:   s_d.cnt = s_q.cnt + CNT_W'(1);
            2'b01:   s_d.cnt = s_q.cnt - CNT_W'(1);
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head  = s_q.mem[s_q.rp];
    assign count = s_q.cnt;
endmodule

// File: rtl/nfc_strobe.sv
module nfc_strobe
    import nfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DLY_W-1:0]  wr_dly,
    input  logic [DLY_W-1:0]  rd_dly,
    input  logic              avail,
    input  wb_entry_t         entry,
    input  logic [BYTE_W-1:0] dq_in,
    output logic              take,
    output logic              busy,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              we_n,
    output logic              re_n,
    output logic              cle,
    output logic              ale,
    output logic [BYTE_W-1:0] dq_out,
    output logic              dq_oe
);
    typedef struct packed {
        logic             active;
        logic [DLY_W-1:0] cnt;
        wb_entry_t        ent;
    } eng_t;

    eng_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        take     = 1'b0;
        rd_valid = 1'b0;
        if (s_q.active) begin
            if (s_q.cnt == '0) begin
                s_d.active = 1'b0;
                rd_valid   = (s_q.ent.tag == TAG_READ);
            end else begin
                s_d.cnt = s_q.cnt - DLY_W'(1);
            end
        end else if (avail) begin
            take       = 1'b1;
            s_d.active = 1'b1;
            s_d.ent    = entry;
            s_d.cnt    = (entry.tag == TAG_READ) ? rd_dly : wr_dly;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy    = s_q.active;
    assign rd_byte = dq_in;
    assign re_n    = !(s_q.active && s_q.ent.tag == TAG_READ);
    assign we_n    = !(s_q.active && s_q.ent.tag != TAG_READ);
    assign cle     = s_q.active && s_q.ent.tag == TAG_CMD;
    assign ale     = s_q.active && s_q.ent.tag == TAG_ADDR;
    assign dq_oe   = !we_n;
    assign dq_out  = s_q.ent.val;
endmodule

// File: rtl/nfc_rb_sync.sv
module nfc_rb_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_async,
    output logic rb_level,
    output logic rb_rise
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.s1 = rb_async;
        s_d.s2 = s_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{s1: 1'b1, s2: 1'b1};
        else        s_q <= s_d;
    end

    assign rb_level = s_q.s2;
    assign rb_rise  = s_q.s1 & ~s_q.s2;
endmodule

// File: rtl/nfc_host_frontend.sv
module nfc_host_frontend
    import nfc_pkg::*;
#(
    parameter int WB_DEPTH = 4,
    parameter int BUS_W    = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic                  bus_wr,
    input  logic [BUS_W-1:0]      bus_wdata,
    output logic [BUS_W-1:0]      bus_rdata,
    output logic                  irq,
    output logic                  nf_cle,
    output logic                  nf_ale,
    output logic                  nf_we_n,
    output logic                  nf_re_n,
    output logic [BYTE_W-1:0]     nf_dq_out,
    output logic                  nf_dq_oe,
    input  logic [BYTE_W-1:0]     nf_dq_in,
    input  logic                  nf_rb
);
    localparam int CNT_W = $clog2(WB_DEPTH + 1);

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [NUM_EV-1:0] mask;
        logic [NUM_EV-1:0] ev;
        logic [BYTE_W-1:0] rdat;
    } regs_t;

    regs_t regs_d, regs_q;

    wb_entry_t         push_entry, head;
    logic [CNT_W-1:0]  wb_count;
    logic              wb_full, wb_push, wb_req;
    logic              take, busy, rd_valid, rb_level, rb_rise;
    logic [BYTE_W-1:0] rd_byte;
    logic [NUM_EV-1:0] ev_set, ev_clr;
    logic [NUM_EV-1:0] status;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata[BUS_W-1:CTRL_W];

    assign wb_full = (wb_count == CNT_W'(WB_DEPTH));
    assign wb_req  = bus_wr && (bus_addr >= OFF_CMD) && (bus_addr <= OFF_RDREQ);
    assign wb_push = wb_req && !wb_full;

    always_comb begin
        push_entry.val = bus_wdata[BYTE_W-1:0];
        case (bus_addr)
            OFF_CMD:  push_entry.tag = TAG_CMD;
            OFF_ADDR: push_entry.tag = TAG_ADDR;
            OFF_DATA: push_entry.tag = TAG_DATA;
            default:  push_entry.tag = TAG_READ;
        endcase
    end

    nfc_wbuf #(.DEPTH(WB_DEPTH)) u_wbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (wb_push),
        .push_entry (push_entry),
        .pop        (take),
        .head       (head),
        .count      (wb_count)
    );

    nfc_strobe u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_dly   (regs_q.ctrl[DLY_W-1:0]),
        .rd_dly   (regs_q.ctrl[2*DLY_W-1:DLY_W]),
        .avail    (wb_count != '0),
        .entry    (head),
        .dq_in    (nf_dq_in),
        .take     (take),
        .busy     (busy),
        .rd_valid (rd_valid),
        .rd_byte  (rd_byte),
        .we_n     (nf_we_n),
        .re_n     (nf_re_n),
        .cle      (nf_cle),
        .ale      (nf_ale),
        .dq_out   (nf_dq_out),
        .dq_oe    (nf_dq_oe)
    );

    nfc_rb_sync u_rb (
        .clk      (clk),
        .rst_n    (rst_n),
        .rb_async (nf_rb),
        .rb_level (rb_level),
        .rb_rise  (rb_rise)
    );

    // next-state of the register file
    always_comb begin
        regs_d = regs_q;
        ev_set = '0;
        ev_clr = '0;
        ev_set[EV_RDY_RISE]   = rb_rise;
        ev_set[EV_OVF]        = wb_req && wb_full;
        ev_set[EV_LEAVE_FULL] = wb_full && take;
        ev_set[EV_RD_READY]   = rd_valid;
        if (rd_valid) regs_d.rdat = rd_byte;
        if (bus_wr) begin
            case (bus_addr)
                OFF_CTRL: regs_d.ctrl = bus_wdata[CTRL_W-1:0];
                OFF_MASK: regs_d.mask = bus_wdata[NUM_EV-1:0];
                OFF_EVT:  ev_clr      = bus_wdata[NUM_EV-1:0];
                default:  ;
            endcase
        end
        regs_d.ev = (regs_q.ev & ~ev_clr) | ev_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign status = {(wb_count == '0) && !busy, 2'b00, wb_full, rb_level};

    always_comb begin
        case (bus_addr)
            OFF_CTRL:  bus_rdata = BUS_W'(regs_q.ctrl);
            OFF_STAT:  bus_rdata = BUS_W'(status);
            OFF_EVT:   bus_rdata = BUS_W'(regs_q.ev);
            OFF_MASK:  bus_rdata = BUS_W'(regs_q.mask);
            OFF_RDATA: bus_rdata = BUS_W'(regs_q.rdat);
            default:   bus_rdata = '0;
        endcase
    end

    assign irq = |(regs_q.ev & regs_q.mask);
endmodule

// File: rtl/nfc_host_frontend_chk.sv
module nfc_host_frontend_chk
    import nfc_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_wr,
    input logic [REG_ADDR_W-1:0] bus_addr,
    input logic                  nf_cle,
    input logic                  nf_ale,
    input logic                  nf_we_n,
    input logic                  nf_re_n,
    input logic                  nf_dq_oe,
    input logic [CNT_W-1:0]      wb_count,
    input logic [NUM_EV-1:0]     ev
);
    assert_cle_ale_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(nf_cle && nf_ale));

    assert_oe_inside_we_R2: assert property (@(posedge clk) disable iff (!rst_n)
        nf_dq_oe |-> !nf_we_n);

    assert_strobes_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        nf_we_n || nf_re_n);

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_count <= CNT_W'(DEPTH));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr >= OFF_CMD && bus_addr <= OFF_RDREQ && wb_count == CNT_W'(DEPTH))
        |=> ev[EV_OVF]);

    assert_read_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nf_re_n) |-> ev[EV_RD_READY]);
endmodule

bind nfc_host_frontend nfc_host_frontend_chk #(.DEPTH(WB_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .nf_cle   (nf_cle),
    .nf_ale   (nf_ale),
    .nf_we_n  (nf_we_n),
    .nf_re_n  (nf_re_n),
    .nf_dq_oe (nf_dq_oe),
    .wb_count (wb_count),
    .ev       (regs_q.ev)
);

// File: tb/sim_nfc_host_frontend.sv
module sim_nfc_host_frontend;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        irq, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
    logic [7:0]  nf_dq_out;
    logic [7:0]  flash_byte = 8'h00;
    logic        nf_rb = 1'b1;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;

    nfc_host_frontend u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
        .nf_dq_out(nf_dq_out), .nf_dq_oe(nf_dq_oe), .nf_dq_in(flash_byte), .nf_rb(nf_rb)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // behavioural reference model
    logic [9:0] m_ctrl = 0;
    logic [4:0] m_mask = 0, m_ev = 0;
    logic [7:0] m_rd = 0;
    logic [9:0] mq[$];
    bit         m_act = 0;
    int         m_cnt = 0;
    logic [1:0] m_tag = 0;
    logic [7:0] m_byte = 0;
    logic       m_s1 = 1, m_s2 = 1;

    always @(posedge clk) begin
        int sz;
        bit full, take;
        logic [4:0] set, clr;
        logic [9:0] c_old;
        if (!rst_n) begin
            m_ctrl = 0; m_mask = 0; m_ev = 0; m_rd = 0; mq.delete();
            m_act = 0; m_cnt = 0; m_tag = 0; m_byte = 0; m_s1 = 1; m_s2 = 1;
        end else begin
            sz = mq.size(); full = (sz == 4); take = 0; set = 0; clr = 0; c_old = m_ctrl;
            if (m_act) begin
                if (m_cnt == 0) begin
                    m_act = 0;
                    if (m_tag == 2'd3) begin m_rd = flash_byte; set[3] = 1; end
                end else m_cnt--;
            end else if (sz > 0) begin
                take = 1;
                {m_tag, m_byte} = mq.pop_front();
                m_act = 1;
                m_cnt = (m_tag == 2'd3) ? int'(c_old[7:4]) : int'(c_old[3:0]);
            end
            if (full && take) set[2] = 1;
            if (m_s1 && !m_s2) set[0] = 1;
            m_s2 = m_s1; m_s1 = nf_rb;
            if (bus_wr) begin
                if (bus_addr == 4'h0) m_ctrl = bus_wdata[9:0];
                else if (bus_addr == 4'h2) clr = bus_wdata[4:0];
                else if (bus_addr == 4'h3) m_mask = bus_wdata[4:0];
                else if (bus_addr >= 4'h4 && bus_addr <= 4'h7) begin
                    if (full) set[1] = 1;
                    else mq.push_back({bus_addr[1:0], bus_wdata[7:0]});
                end
            end
            m_ev = (m_ev & ~clr) | set;
        end
    end

    // per-cycle comparison and flash-side logging
    logic [9:0] flog[$];
    logic [9:0] we_save;
    bit we_prev_low = 0, re_prev_low = 0;
    int we_run = 0, re_run = 0, last_we_len = 0, last_re_len = 0;

    always @(posedge clk) begin
        logic [15:0] e;
        #5;
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog (all): cycles=%0d expected < 100000", cycles);
            finish_run();
        end
        if (rst_n && !done) begin
            chk(nf_we_n == !(m_act && m_tag != 2'd3), "R4 we_n", nf_we_n, !(m_act && m_tag != 2'd3));
            chk(nf_re_n == !(m_act && m_tag == 2'd3), "R5 re_n", nf_re_n, !(m_act && m_tag == 2'd3));
            chk({nf_cle, nf_ale} == {m_act && m_tag == 2'd0, m_act && m_tag == 2'd1}, "R2 cle/ale",
                {nf_cle, nf_ale}, {m_act && m_tag == 2'd0, m_act && m_tag == 2'd1});
            chk(nf_dq_oe == (m_act && m_tag != 2'd3), "R2 dq_oe", nf_dq_oe, (m_act && m_tag != 2'd3));
            if (nf_dq_oe) chk(nf_dq_out == m_byte, "R2 dq_out", nf_dq_out, m_byte);
            chk(irq == |(m_ev & m_mask), "R8 irq", irq, |(m_ev & m_mask));
            case (bus_addr)
                4'h0: e = {6'b0, m_ctrl};
                4'h1: e = {11'b0, (mq.size() == 0 && !m_act), 2'b00, (mq.size() == 4), m_s2};
                4'h2: e = {11'b0, m_ev};
                4'h3: e = {11'b0, m_mask};
                4'h8: e = {8'b0, m_rd};
                default: e = 16'h0;
            endcase
            chk(bus_rdata == e, "R6/R7 readback", bus_rdata, e);
            if (!nf_we_n) begin
                we_save = {nf_cle, nf_ale, nf_dq_out}; we_run++; we_prev_low = 1;
            end else if (we_prev_low) begin
                flog.push_back(we_save); last_we_len = we_run; we_run = 0; we_prev_low = 0;
            end
            if (!nf_re_n) begin re_run++; re_prev_low = 1; end
            else if (re_prev_low) begin last_re_len = re_run; re_run = 0; re_prev_low = 0; end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk); bus_wr = 0; bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic wait_drained();
        logic [15:0] v;
        for (int i = 0; i < 500; i++) begin
            rd(4'h1, v);
            if (v[4]) break;
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        logic [15:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R9: reset state
        rd(4'h1, v); chk(v == 16'h0011, "R9 status after reset", v, 16'h0011);
        rd(4'h2, v); chk(v == 16'h0, "R9 events after reset", v, 0);
        rd(4'h0, v); chk(v == 16'h0, "R9 ctrl after reset", v, 0);
        chk(nf_we_n && nf_re_n && !nf_cle && !nf_ale && !irq, "R9 pins after reset",
            {nf_we_n, nf_re_n, nf_cle, nf_ale, irq}, 5'b11000);

        // R1: control readback
        wr(4'h0, 16'h0032);
        rd(4'h0, v); chk(v == 16'h0032, "R1 ctrl readback", v, 16'h0032);

        // R2: command then address ordering with latch lines
        flog.delete();
        wr(4'h4, 16'h0090); wr(4'h5, 16'h0000); wr(4'h6, 16'h005A);
        wait_drained();
        chk(flog.size() == 3, "R2 byte count", flog.size(), 3);
        if (flog.size() == 3) begin
            chk(flog[0] == 10'h290, "R2 command with CLE", flog[0], 10'h290);
            chk(flog[1] == 10'h100, "R2 address with ALE", flog[1], 10'h100);
            chk(flog[2] == 10'h05A, "R2 data without latches", flog[2], 10'h05A);
        end
        chk(last_we_len == 3, "R4 WE width wr_dly=2", last_we_len, 3);

        // R5: read request, fetch, acknowledge
        flash_byte = 8'hEC;
        wr(4'h7, 16'h0000);
        for (int i = 0; i < 100; i++) begin rd(4'h2, v); if (v[3]) break; end
        chk(v[3] == 1'b1, "R5 read-ready set", v[3], 1);
        rd(4'h8, v); chk(v == 16'h00EC, "R5 read data", v, 16'h00EC);
        chk(last_re_len == 4, "R4 RE width rd_dly=3", last_re_len, 4);
        wr(4'h2, 16'h0008);
        rd(4'h2, v); chk(v[3] == 1'b0, "R7 W1C of read-ready", v[3], 0);

        // R3: burst of six into a four-deep buffer
        flog.delete();
        @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            bus_wr = 1; bus_addr = 4'h6; bus_wdata = 16'h00A0 + 16'(i);
            @(negedge clk);
        end
        bus_wr = 0;
        wait_drained();
        chk(flog.size() == 5, "R3 one byte dropped", flog.size(), 5);
        if (flog.size() == 5) chk(flog[4] == 10'h0A4, "R3 last accepted byte", flog[4], 10'h0A4);
        rd(4'h2, v); chk(v[2:1] == 2'b11, "R3/R7 overflow and leave-full events", v[2:1], 2'b11);

        // R8: mask drives irq
        wr(4'h3, 16'h0002);
        rd(4'h3, v); chk(irq == 1'b1, "R8 irq with masked overflow", irq, 1);
        wr(4'h2, 16'h001F);
        rd(4'h2, v); chk(v == 16'h0, "R7 clear all", v, 0);
        chk(irq == 1'b0, "R8 irq after clear", irq, 0);

        // R6/R7: ready line and its edge event
        nf_rb = 0;
        repeat (4) @(negedge clk);
        rd(4'h1, v); chk(v[0] == 1'b0, "R6 busy reported", v[0], 0);
        nf_rb = 1;
        repeat (4) @(negedge clk);
        rd(4'h1, v); chk(v[0] == 1'b1, "R6 ready reported", v[0], 1);
        rd(4'h2, v); chk(v[0] == 1'b1, "R7 ready-rise event", v[0], 1);

        // R1: width/page bits do not alter timing; zero delays
        wr(4'h0, 16'h0321);
        wr(4'h6, 16'h0011);
        wait_drained();
        chk(last_we_len == 2, "R1 WE width unaffected by bits 8/9", last_we_len, 2);
        wr(4'h0, 16'h0000);
        flash_byte = 8'h3C;
        wr(4'h6, 16'h0022); wr(4'h7, 16'h0000);
        wait_drained();
        chk(last_we_len == 1, "R4 minimum WE width", last_we_len, 1);
        chk(last_re_len == 1, "R4 minimum RE width", last_re_len, 1);
        rd(4'h8, v); chk(v == 16'h003C, "R5 read data at zero delay", v, 16'h003C);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule